// File: doc/BRIEF.md
# Block-Aware Luma Coring Noise Reducer

This block cleans or sharpens a luma stream in which each pixel occupies two clock cycles. For every pixel it forms a signed detail value: the pixel minus the average of its left and right neighbours. The magnitude of that detail is compared with a 6-bit threshold. In noise-reduction mode, small detail is treated as noise: it is scaled and subtracted. In sharpening mode, large detail is treated as edges: it is scaled and added back.

The scaling gain depends on where the pixel sits in the grid of compressed-video blocks. Horizontal and vertical position counters follow the stream, restarting on line and frame starts. Pixels close to a block boundary use a border gain. All other pixels use an interior gain. The block size and the width of the border zone can each be selected. Results leave in stream order, one per pixel, with a fixed pipeline delay.

Top module: `luma_coring_nr`

## Requirements
- R1: After the first frame start, one pixel is sampled every second clock. A cycle with `frameStart` or `lineStart` high always samples a pixel and restarts that two-cycle cadence.
- R2: The detail of pixel c is d = c - floor((l + r) / 2), where l and r are its left and right neighbours in the stream. A neighbour across a line start is replaced by c itself. This applies to the left neighbour of the first pixel of a line and to the right neighbour of the last pixel of a line.
- R3: With `sharpenMode` = 0 and |d| < threshold, the output is c - floor(d * n / 8), where n is the effective gain code. Otherwise the output is c.
- R4: With `sharpenMode` = 1 and |d| > threshold, the output is c + floor(d * n / 16). Otherwise the output is c.
- R5: A gain code from 9 to 15 acts as code 8. Code 8 is the maximum gain: 1 in noise-reduction mode and 1/2 in sharpening mode.
- R6: A border pixel uses `gainBorder`. Every other pixel uses `gainInterior`. A pixel is a border pixel when either its column offset or its row offset within the block lies in the border zone. The zone covers offsets 0 .. h-1 and S-h .. S-1, where S is the block size and h is half the zone width.
- R7: `largeBlocks` = 1 selects S = 16. `largeBlocks` = 0 selects S = 8.
- R8: `wideBorder` = 1 selects a zone four pixels wide (h = 2). `wideBorder` = 0 selects a zone two pixels wide (h = 1).
- R9: The column counter is 0 at each line start and counts sampled pixels. The row counter is 0 at a frame start and advances by one at each further line start.
- R10: The output luma is clamped to the range 0 to 255.
- R11: `lumaOutValid` is high for one cycle per pixel, in stream order. It rises 3 cycles after the sampling cycle of the following pixel. In a steady stream this is 5 cycles after the pixel's own sampling cycle.
- R12: While reset is held, and before the first frame start, `lumaOutValid` and `lumaOut` are 0 and no pixel is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lumaIn | input | 8 | Incoming luma sample |
| lineStart | input | 1 | High in the sampling cycle of a line's first pixel |
| frameStart | input | 1 | High in the sampling cycle of a frame's first pixel |
| sharpenMode | input | 1 | 0 noise reduction, 1 sharpening |
| coreThreshold | input | 6 | Detail magnitude threshold, 0 to 63 |
| gainBorder | input | 4 | Gain code for border-zone pixels |
| gainInterior | input | 4 | Gain code for block-interior pixels |
| largeBlocks | input | 1 | 1 selects 16x16 blocks, 0 selects 8x8 |
| wideBorder | input | 1 | 1 selects a 4-pixel zone, 0 a 2-pixel zone |
| lumaOut | output | 8 | Corrected luma |
| lumaOutValid | output | 1 | One-cycle strobe marking a new result |

## Verification
The hardest case to reach is a pixel whose gain choice depends only on its row. This needs a frame tall enough to cross a 16-line block boundary, and a frame start that really resets the row count.

The stimulus streams frames of 18 lines and a short frame of 5 lines directly followed by a full one. Without a working frame-start reset, the second frame's row zones would be shifted.

The border and interior gains are set far apart, with zero against full gain, so every misplaced zone pixel changes the output. A reference model then scores every pixel of every frame.

// File: rtl/luma_nr_pkg.sv
package luma_nr_pkg;

  // Per-pixel strobes passed from control to datapath
  typedef struct packed {
    logic accept;     // a pixel is sampled this cycle
    logic lineFirst;  // sampled pixel is the first of its line
    logic border;     // sampled pixel lies in a block border zone
  } pixStrobe_t;

endpackage

// File: rtl/luma_nr_edge_zone.sv
module luma_nr_edge_zone #(
  parameter int POS_W     = 12,
  parameter int BASE_LOG2 = 3
) (
  input  logic [POS_W-1:0] pos,
  input  logic             largeBlocks,
  input  logic             wideBorder,
  output logic             inZone
);

  localparam logic [POS_W-1:0] SMALL_MASK = POS_W'((1 << BASE_LOG2) - 1);
  localparam logic [POS_W-1:0] LARGE_MASK = POS_W'((1 << (BASE_LOG2 + 1)) - 1);

  logic [POS_W-1:0] blockMask;
  logic [POS_W-1:0] offset;
  logic [POS_W-1:0] halfZone;

  always_comb begin
    blockMask = largeBlocks ? LARGE_MASK : SMALL_MASK;
    offset    = pos & blockMask;
    halfZone  = wideBorder ? POS_W'(2) : POS_W'(1);
    inZone    = (offset < halfZone) || (offset > (blockMask - halfZone));
  end

endmodule

// File: rtl/luma_nr_ctrl.sv
module luma_nr_ctrl
  import luma_nr_pkg::*;
#(
  parameter int POS_W     = 12,
  parameter int BASE_LOG2 = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineStart,
  input  logic       frameStart,
  input  logic       largeBlocks,
  input  logic       wideBorder,
  output pixStrobe_t strb
);

  localparam int AXES = 2;

  logic             phaseQ;
  logic             syncedQ;
  logic [POS_W-1:0] hCountQ;
  logic [POS_W-1:0] vLineQ;
  logic             startPix;
  logic             accept;
  logic [POS_W-1:0] curH;
  logic [POS_W-1:0] curV;
  logic [POS_W-1:0] axisPos [AXES];
  logic [AXES-1:0]  zoneHit;

  assign startPix = lineStart | frameStart;
  assign accept   = frameStart | (syncedQ & (lineStart | ~phaseQ));

  always_comb begin
    curH = startPix ? '0 : hCountQ;
    if (frameStart)     curV = '0;
    else if (lineStart) curV = vLineQ + POS_W'(1);
    else                curV = vLineQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ  <= 1'b0;
      syncedQ <= 1'b0;
      hCountQ <= '0;
      vLineQ  <= '0;
    end else begin
      if (frameStart) syncedQ <= 1'b1;
      if (startPix) phaseQ <= 1'b1;
      else          phaseQ <= ~phaseQ;
      if (accept) begin
        hCountQ <= curH + POS_W'(1);
        vLineQ  <= curV;
      end
    end
  end

  assign axisPos[0] = curH;
  assign axisPos[1] = curV;

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    luma_nr_edge_zone #(
      .POS_W    (POS_W),
      .BASE_LOG2(BASE_LOG2)
    ) u_zone (
      .pos        (axisPos[a]),
      .largeBlocks(largeBlocks),
      .wideBorder (wideBorder),
      .inZone     (zoneHit[a])
    );
  end

  assign strb.accept    = accept;
  assign strb.lineFirst = startPix;
  assign strb.border    = |zoneHit;

  // R1
  accept_cadence_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |=> (!strb.accept || lineStart || frameStart));

  // R9
  frame_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (strb.accept && strb.lineFirst && strb.border));

endmodule

// File: rtl/luma_nr_datapath.sv
module luma_nr_datapath
  import luma_nr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int THR_W  = 6,
  parameter int GAIN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  pixStrobe_t        strb,
  input  logic [DATA_W-1:0] lumaIn,
  input  logic              sharpenMode,
  input  logic [THR_W-1:0]  coreThreshold,
  input  logic [GAIN_W-1:0] gainBorder,
  input  logic [GAIN_W-1:0] gainInterior,
  output logic [DATA_W-1:0] lumaOut,
  output logic              lumaOutValid
);

  localparam int DET_W  = DATA_W + 2;
  localparam int GC_W   = GAIN_W + 1;
  localparam int PROD_W = DET_W + GC_W;
  localparam int RES_W  = PROD_W + 1;
  localparam logic [GAIN_W-1:0] GAIN_MAX = GAIN_W'(1 << (GAIN_W - 1));
  localparam logic signed [RES_W-1:0] PIX_MAX = RES_W'((1 << DATA_W) - 1);

  // three-pixel window
  logic [DATA_W-1:0] leftQ, cenQ, rightQ;
  logic cenFirstQ, rightFirstQ;
  logic cenBorderQ, rightBorderQ;
  logic cenValidQ, rightValidQ;
  logic evalQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leftQ        <= '0;
      cenQ         <= '0;
      rightQ       <= '0;
      cenFirstQ    <= 1'b0;
      rightFirstQ  <= 1'b0;
      cenBorderQ   <= 1'b0;
      rightBorderQ <= 1'b0;
      cenValidQ    <= 1'b0;
      rightValidQ  <= 1'b0;
      evalQ        <= 1'b0;
    end else begin
      evalQ <= strb.accept;
      if (strb.accept) begin
        leftQ        <= cenQ;
        cenQ         <= rightQ;
        rightQ       <= lumaIn;
        cenFirstQ    <= rightFirstQ;
        rightFirstQ  <= strb.lineFirst;
        cenBorderQ   <= rightBorderQ;
        rightBorderQ <= strb.border;
        cenValidQ    <= rightValidQ;
        rightValidQ  <= 1'b1;
      end
    end
  end

  // detail filter and threshold test
  logic [DATA_W-1:0]       leftEff, rightEff, avgPix;
  logic [DATA_W:0]         pairSum;
  logic signed [DET_W-1:0] detail;
  logic [DET_W-1:0]        detailMag;
  logic [DET_W-1:0]        thrExt;
  logic                    passSel;
  logic [GAIN_W-1:0]       gainRaw, gainSat;

  always_comb begin
    leftEff   = cenFirstQ ? cenQ : leftQ;
    rightEff  = rightFirstQ ? cenQ : rightQ;
    pairSum   = {1'b0, leftEff} + {1'b0, rightEff};
    avgPix    = pairSum[DATA_W:1];
    detail    = $signed({2'b00, cenQ}) - $signed({2'b00, avgPix});
    detailMag = detail[DET_W-1] ? DET_W'(-detail) : DET_W'(detail);
    thrExt    = DET_W'(coreThreshold);
    passSel   = sharpenMode ? (detailMag > thrExt) : (detailMag < thrExt);
    gainRaw   = cenBorderQ ? gainBorder : gainInterior;
    gainSat   = (gainRaw > GAIN_MAX) ? GAIN_MAX : gainRaw;
  end

  // stage 1 registers
  logic                    s1Valid;
  logic [DATA_W-1:0]       s1Cen;
  logic signed [DET_W-1:0] s1Det;
  logic                    s1Pass;
  logic [GAIN_W-1:0]       s1Gain;
  logic                    s1Sharp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Cen   <= '0;
      s1Det   <= '0;
      s1Pass  <= 1'b0;
      s1Gain  <= '0;
      s1Sharp <= 1'b0;
    end else begin
      s1Valid <= evalQ & cenValidQ;
      if (evalQ) begin
        s1Cen   <= cenQ;
        s1Det   <= detail;
        s1Pass  <= passSel;
        s1Gain  <= gainSat;
        s1Sharp <= sharpenMode;
      end
    end
  end

  // stage 2: scale, apply, clamp
  logic signed [PROD_W-1:0] prod, scaled;
  logic signed [RES_W-1:0]  cenExt, scaledExt, adjusted;
  logic [DATA_W-1:0]        clamped;

  always_comb begin
    prod      = PROD_W'(s1Det) * PROD_W'($signed({1'b0, s1Gain}));
    scaled    = s1Sharp ? (prod >>> GAIN_W) : (prod >>> (GAIN_W - 1));
    cenExt    = $signed({{(RES_W - DATA_W){1'b0}}, s1Cen});
    scaledExt = RES_W'(scaled);
    if (!s1Pass)      adjusted = cenExt;
    else if (s1Sharp) adjusted = cenExt + scaledExt;
    else              adjusted = cenExt - scaledExt;
    if (adjusted < 0)            clamped = '0;
    else if (adjusted > PIX_MAX) clamped = '1;
    else                         clamped = adjusted[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lumaOut      <= '0;
      lumaOutValid <= 1'b0;
    end else begin
      lumaOutValid <= s1Valid;
      if (s1Valid) lumaOut <= clamped;
    end
  end

  // R11
  out_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    lumaOutValid |-> $past(strb.accept, 3));

  // R3
  nr_direction_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lumaOutValid && !$past(s1Sharp)) |->
      ($past(s1Det[DET_W-1]) ? (lumaOut >= $past(s1Cen)) : (lumaOut <= $past(s1Cen))));

  // R4
  sharp_direction_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lumaOutValid && $past(s1Sharp)) |->
      ($past(s1Det[DET_W-1]) ? (lumaOut <= $past(s1Cen)) : (lumaOut >= $past(s1Cen))));

endmodule

// File: rtl/luma_coring_nr.sv
module luma_coring_nr
  import luma_nr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int THR_W     = 6,
  parameter int GAIN_W    = 4,
  parameter int POS_W     = 12,
  parameter int BASE_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] lumaIn,
  input  logic              lineStart,
  input  logic              frameStart,
  input  logic              sharpenMode,
  input  logic [THR_W-1:0]  coreThreshold,
  input  logic [GAIN_W-1:0] gainBorder,
  input  logic [GAIN_W-1:0] gainInterior,
  input  logic              largeBlocks,
  input  logic              wideBorder,
  output logic [DATA_W-1:0] lumaOut,
  output logic              lumaOutValid
);

  pixStrobe_t strb;

  luma_nr_ctrl #(
    .POS_W    (POS_W),
    .BASE_LOG2(BASE_LOG2)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lineStart  (lineStart),
    .frameStart (frameStart),
    .largeBlocks(largeBlocks),
    .wideBorder (wideBorder),
    .strb       (strb)
  );

  luma_nr_datapath #(
    .DATA_W(DATA_W),
    .THR_W (THR_W),
    .GAIN_W(GAIN_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .lumaIn       (lumaIn),
    .sharpenMode  (sharpenMode),
    .coreThreshold(coreThreshold),
    .gainBorder   (gainBorder),
    .gainInterior (gainInterior),
    .lumaOut      (lumaOut),
    .lumaOutValid (lumaOutValid)
  );

endmodule

// File: tb/test_luma_coring_nr.sv
`timescale 1ns/1ps
module test_luma_coring_nr;

  localparam int MAXP  = 1024;
  localparam int WIDTH = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] lumaIn = 8'd0;
  logic       lineStart = 1'b0;
  logic       frameStart = 1'b0;
  logic       sharpenMode = 1'b0;
  logic [5:0] coreThreshold = 6'd0;
  logic [3:0] gainBorder = 4'd0;
  logic [3:0] gainInterior = 4'd0;
  logic       largeBlocks = 1'b0;
  logic       wideBorder = 1'b0;
  logic [7:0] lumaOut;
  logic       lumaOutValid;

  always #2 clk = ~clk;

  luma_coring_nr i_luma_coring_nr (
    .clk(clk), .rstN(rstN), .lumaIn(lumaIn), .lineStart(lineStart),
    .frameStart(frameStart), .sharpenMode(sharpenMode),
    .coreThreshold(coreThreshold), .gainBorder(gainBorder),
    .gainInterior(gainInterior), .largeBlocks(largeBlocks),
    .wideBorder(wideBorder), .lumaOut(lumaOut), .lumaOutValid(lumaOutValid)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;
  int unsigned seed = 32'h1234_5678;

  int sPix [MAXP];
  bit sLs  [MAXP];
  bit sFs  [MAXP];
  int sX   [MAXP];
  int sY   [MAXP];
  int sLen = 0;
  int fsCyc = 0;

  int outs   [MAXP];
  int outCyc [MAXP];
  int capN = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN && lumaOutValid && capN < MAXP) begin
      outs[capN]   = lumaOut;
      outCyc[capN] = cyc;
      capN = capN + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'h7fff);
  endfunction

  function automatic int genPix(int pat, int x, int y);
    int v;
    case (pat)
      0: begin
        v = 100 + (rnd() % 13) - 6;
        if (x % 7 == 3) v = v + 45;
      end
      1: begin
        v = (((x / 3) + y) % 2 == 1) ? 220 : 30;
        v = v + (rnd() % 9) - 4;
        if (x % 5 == 0) v = (y % 2 == 1) ? 255 : 0;
      end
      default: v = 10 * x + (rnd() % 21);
    endcase
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  task automatic addFrame(input int rows, input int pat);
    for (int y = 0; y < rows; y++) begin
      for (int x = 0; x < WIDTH; x++) begin
        sPix[sLen] = genPix(pat, x, y);
        sLs[sLen]  = (x == 0);
        sFs[sLen]  = (x == 0) && (y == 0);
        sX[sLen]   = x;
        sY[sLen]   = y;
        sLen++;
      end
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    lineStart = 1'b0;
    frameStart = 1'b0;
    repeat (3) @(negedge clk);
    capN = 0;
    sLen = 0;
    rstN = 1'b1;
  endtask

  // one pixel per two clocks; the flush pixel carries a line start
  task automatic playStream();
    for (int i = 0; i <= sLen; i++) begin
      @(negedge clk);
      if (i == 0) fsCyc = cyc;
      lumaIn     = (i < sLen) ? 8'(sPix[i]) : 8'd0;
      lineStart  = (i < sLen) ? sLs[i] : 1'b1;
      frameStart = (i < sLen) ? sFs[i] : 1'b0;
      @(negedge clk);
      lineStart  = 1'b0;
      frameStart = 1'b0;
    end
    for (int w = 0; w < 40 && capN < sLen; w++) @(negedge clk);
  endtask

  function automatic int model(int i);
    int c, l, r, d, n, hs, hf, ox, oy, p, res;
    bit brd, pass;
    c  = sPix[i];
    l  = sLs[i] ? c : sPix[i-1];
    r  = (i + 1 >= sLen || sLs[i+1]) ? c : sPix[i+1];
    d  = c - ((l + r) >>> 1);
    hs = largeBlocks ? 16 : 8;
    hf = wideBorder ? 2 : 1;
    ox = sX[i] % hs;
    oy = sY[i] % hs;
    brd = (ox < hf) || (ox >= hs - hf) || (oy < hf) || (oy >= hs - hf);
    n  = brd ? gainBorder : gainInterior;
    if (n > 8) n = 8;
    p  = d * n;
    if (sharpenMode) begin
      pass = ((d < 0) ? -d : d) > coreThreshold;
      res  = pass ? c + (p >>> 4) : c;
    end else begin
      pass = ((d < 0) ? -d : d) < coreThreshold;
      res  = pass ? c - (p >>> 3) : c;
    end
    if (res < 0) res = 0;
    if (res > 255) res = 255;
    return res;
  endfunction

  task automatic scoreStream(input string req);
    check(capN >= sLen, "R11", capN, sLen, "result count");
    for (int i = 0; i < sLen && i < capN; i++)
      check(outs[i] == model(i), req, outs[i], model(i), $sformatf("pixel %0d (x%0d y%0d)", i, sX[i], sY[i]));
  endtask

  // R12: reset state, and nothing sampled before a frame start
  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(lumaOutValid == 1'b0, "R12", lumaOutValid, 0, "valid in reset");
    check(lumaOut == 8'd0, "R12", lumaOut, 0, "luma in reset");
    capN = 0;
    rstN = 1'b1;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      lumaIn = 8'(k * 9);
      lineStart = (k % 6 == 0);
    end
    lineStart = 1'b0;
    repeat (6) @(negedge clk);
    check(capN == 0, "R12", capN, 0, "results before frame start");
  endtask

  // R3, R6, R7, R8: noise reduction, 8x8 blocks, narrow zone, zero border gain
  task automatic t_nr_small_blocks();
    doReset();
    sharpenMode = 0; coreThreshold = 6'd30; gainBorder = 4'd0; gainInterior = 4'd8;
    largeBlocks = 0; wideBorder = 0;
    addFrame(18, 0);
    playStream();
    scoreStream("R3 R6 R7 R8");
  endtask

  // R2, R3, R6, R7, R8: noise reduction, 16x16 blocks, wide zone, ramp pattern
  task automatic t_nr_large_blocks();
    doReset();
    sharpenMode = 0; coreThreshold = 6'd63; gainBorder = 4'd8; gainInterior = 4'd3;
    largeBlocks = 1; wideBorder = 1;
    addFrame(18, 2);
    playStream();
    scoreStream("R2 R3 R6 R7 R8");
  endtask

  // R4, R10: sharpening with clamping on full-swing content
  task automatic t_sharpen();
    doReset();
    sharpenMode = 1; coreThreshold = 6'd10; gainBorder = 4'd3; gainInterior = 4'd8;
    largeBlocks = 1; wideBorder = 0;
    addFrame(18, 1);
    playStream();
    scoreStream("R4 R10");
  endtask

  // R5: codes above 8 saturate in both modes
  task automatic t_saturate();
    doReset();
    sharpenMode = 0; coreThreshold = 6'd40; gainBorder = 4'd15; gainInterior = 4'd12;
    largeBlocks = 0; wideBorder = 1;
    addFrame(10, 0);
    playStream();
    scoreStream("R5");
    doReset();
    sharpenMode = 1; coreThreshold = 6'd5; gainBorder = 4'd9; gainInterior = 4'd13;
    addFrame(10, 1);
    playStream();
    scoreStream("R5 R10");
  endtask

  // R9: short frame followed by a full frame; rows must restart at 0
  task automatic t_two_frames();
    doReset();
    sharpenMode = 0; coreThreshold = 6'd50; gainBorder = 4'd0; gainInterior = 4'd8;
    largeBlocks = 1; wideBorder = 1;
    addFrame(5, 0);
    addFrame(18, 0);
    playStream();
    scoreStream("R9 R6");
  endtask

  // R1, R11: cadence and latency of the result strobe
  task automatic t_latency();
    doReset();
    sharpenMode = 0; coreThreshold = 6'd20; gainBorder = 4'd4; gainInterior = 4'd4;
    largeBlocks = 0; wideBorder = 0;
    addFrame(3, 2);
    playStream();
    check(capN >= 2, "R11", capN, 2, "results seen");
    check(outCyc[0] - fsCyc == 5, "R11", outCyc[0] - fsCyc, 5, "first result delay");
    check(outCyc[1] - outCyc[0] == 2, "R1", outCyc[1] - outCyc[0], 2, "result spacing");
    scoreStream("R1 R2");
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    t_reset();
    t_nr_small_blocks();
    t_nr_large_blocks();
    t_sharpen();
    t_saturate();
    t_two_frames();
    t_latency();
    finish();
  end

endmodule